// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two levels of translation tables that sit in memory. The caller supplies the base of the first-level table and asserts a request with the address, a write flag and a user-mode flag. The walker then issues single-word reads and write-backs through a request/acknowledge memory port. At each level it checks the entry it read. The walk ends with either a one-cycle completion pulse carrying the physical address and two caching hints, or a one-cycle fault pulse carrying a cause code and the table level that failed.

Entries are 32 bits wide. The frame number is in bits 31-12 and bits 11-9 are left to software. The walker uses these bits:

| Bit | Meaning |
|-----|---------|
| 0 | present |
| 1 | writeable |
| 2 | user |
| 3 | write-through |
| 4 | cache-disable |
| 5 | accessed |
| 6 | dirty |
| 7 | large page (first level only) |

A first-level entry with bit 7 set maps a 4 MB region directly. Each entry that passes its checks is written back with its accessed bit set. A second-level entry reached by a write is also written back with its dirty bit set.

Top module: `pt_walker`

## Requirements
- R1: The first-level entry is read at address {root_base[31:12], vaddr[31:22], 2'b00}. The second-level entry is read at {directory frame, vaddr[21:12], 2'b00}.
- R2: A walk that ends at a second-level entry returns paddr = {entry[31:12], vaddr[11:0]} with a single-cycle `done` pulse.
- R3: A first-level entry with bit 7 set ends the walk at that level, with no second-level read. It returns paddr = {entry[31:22], vaddr[21:0]}.
- R4: The present bit (bit 0) is checked first at both levels. If it is clear, the walk ends with `fault`, cause 1 and level 0 for the first level or 1 for the second, and that entry is not written back.
- R5: If the present bit is set, a write to an entry with bit 1 clear gives cause 2. Otherwise, a user-mode access to an entry with bit 2 clear gives cause 3. The write check takes priority, and both checks apply at both levels.
- R6: Every entry that passes its checks is written back to the same address before the result. The written value has bit 5 set. A second-level entry reached by a write also has bit 6 set. The walker never sets bit 6 in a first-level entry.
- R7: On completion, `cache_off` and `write_thru` equal bits 4 and 3 of the final entry.
- R8: Only one memory access is in flight at a time. While `mem_req` is high and `mem_ack` is low, the request, address, write flag and write data stay unchanged.
- R9: Each accepted request produces exactly one result, either `done` or `fault`, lasting one cycle. The two never rise together.
- R10: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the result cycle. `req_valid` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | First-level table base (bits 31-12 used) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress; new requests held off |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Entry value written back |
| mem_ack | input | 1 | One-cycle completion of the memory access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | Successful translation pulse |
| paddr | output | 32 | Physical address, valid from the done pulse |
| cache_off | output | 1 | Cache-disable bit of the final entry |
| write_thru | output | 1 | Write-through bit of the final entry |
| fault | output | 1 | Translation fault pulse |
| fault_cause | output | 2 | 1 not present, 2 write protection, 3 user protection |
| fault_level | output | 1 | 0 first-level entry, 1 second-level entry |

## Verification
The assertions assume the memory side obeys a one-outstanding protocol:
- `mem_ack` is a single-cycle pulse that answers a `mem_req` already raised.
- `mem_ack` is never given twice for one access.
- `root_base` does not change during a walk.

The bench's memory model keeps to these rules by design. It acknowledges only a pending request, after a chosen latency of zero to two cycles, and it skips the edge on which it just acknowledged. `root_base` is a bench constant. The stimulus also raises `req_valid` once during a walk, to show that the walker does not act on it.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] root_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] paddr,
  output logic        cache_off,
  output logic        write_thru,
  output logic        fault,
  output logic [1:0]  fault_cause,
  output logic        fault_level
);
  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_WT    = 3;
  localparam int B_CD    = 4;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_LARGE = 7;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_PG, S_WB_PG} st_t;

  st_t         state;
  logic [31:0] va;
  logic [31:0] ent;
  logic [19:0] dir_frame;
  logic        wr, usr;
  logic [1:0]  cause_c;
  logic        at_dir;

  assign at_dir   = (state == S_RD_DIR) || (state == S_WB_DIR);
  assign busy     = (state != S_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (state == S_WB_DIR) || (state == S_WB_PG);
  assign mem_addr = at_dir ? {root_base[31:12], va[31:22], 2'b00}
                           : {dir_frame, va[21:12], 2'b00};

  always_comb begin
    mem_wdata        = ent;
    mem_wdata[B_ACC] = 1'b1;
    if (state == S_WB_PG && wr) mem_wdata[B_DIRTY] = 1'b1;
  end

  always_comb begin
    if (!mem_rdata[B_PRES])            cause_c = 2'd1;
    else if (wr && !mem_rdata[B_WR])   cause_c = 2'd2;
    else if (usr && !mem_rdata[B_USR]) cause_c = 2'd3;
    else                               cause_c = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      va          <= '0;
      ent         <= '0;
      dir_frame   <= '0;
      wr          <= 1'b0;
      usr         <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      paddr       <= '0;
      cache_off   <= 1'b0;
      write_thru  <= 1'b0;
      fault_cause <= 2'd0;
      fault_level <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr;
          wr    <= req_write;
          usr   <= req_user;
          state <= S_RD_DIR;
        end
        S_RD_DIR, S_RD_PG: if (mem_ack) begin
          if (cause_c != 2'd0) begin
            fault       <= 1'b1;
            fault_cause <= cause_c;
            fault_level <= (state == S_RD_PG);
            state       <= S_IDLE;
          end else begin
            ent   <= mem_rdata;
            state <= (state == S_RD_DIR) ? S_WB_DIR : S_WB_PG;
          end
        end
        S_WB_DIR: if (mem_ack) begin
          if (ent[B_LARGE]) begin
            done       <= 1'b1;
            paddr      <= {ent[31:22], va[21:0]};
            cache_off  <= ent[B_CD];
            write_thru <= ent[B_WT];
            state      <= S_IDLE;
          end else begin
            dir_frame <= ent[31:12];
            state     <= S_RD_PG;
          end
        end
        S_WB_PG: if (mem_ack) begin
          done       <= 1'b1;
          paddr      <= {ent[31:12], va[11:0]};
          cache_off  <= ent[B_CD];
          write_thru <= ent[B_WT];
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R4
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |-> fault_cause != 2'd0);

  // R6
  accessed_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_ack |-> mem_wdata[B_ACC]);

  // R6
  dir_no_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB_DIR) |-> mem_wdata[B_DIRTY] == ent[B_DIRTY]);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = 32'h0001_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, paddr;
  logic        done, cache_off, write_thru, fault, fault_level;
  logic [1:0]  fault_cause;

  always #2 clk = ~clk;

  pt_walker u0 (.*);

  typedef struct packed {
    logic        is_fault;
    logic [31:0] pa;
    logic        cd;
    logic        wt;
    logic [1:0]  cause;
    logic        lvl;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] alog[$];
  int          lat = 0, cnt = 0;
  int          n_chk = 0, n_fail = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        cnt = 0;
        alog.push_back(mem_addr);
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_ack <= 1'b1;
      end else cnt++;
    end
  end

  function automatic logic [1:0] perm(input logic [31:0] e, input logic w, input logic u);
    if (!e[0]) return 2'd1;
    if (w && !e[1]) return 2'd2;
    if (u && !e[2]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic w, input logic u);
    exp_t r;
    logic [31:0] d, l;
    r = '0;
    d = rd({root_base[31:12], va[31:22], 2'b00});
    if (perm(d, w, u) != 0) begin
      r.is_fault = 1; r.cause = perm(d, w, u); r.lvl = 0; return r;
    end
    if (d[7]) begin
      r.pa = {d[31:22], va[21:0]}; r.cd = d[4]; r.wt = d[3]; return r;
    end
    l = rd({d[31:12], va[21:12], 2'b00});
    if (perm(l, w, u) != 0) begin
      r.is_fault = 1; r.cause = perm(l, w, u); r.lvl = 1; return r;
    end
    r.pa = {l[31:12], va[11:0]}; r.cd = l[4]; r.wt = l[3];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      if (sb.size() == 0) chk(0, "R9 unexpected result", {31'b0, done}, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(fault == e.is_fault && done == !e.is_fault, "R9 outcome kind", {31'b0, fault}, {31'b0, e.is_fault});
        if (e.is_fault)
          chk(fault_cause == e.cause && fault_level == e.lvl, "R4/R5 cause and level",
              {29'b0, fault_level, fault_cause}, {29'b0, e.lvl, e.cause});
        else begin
          chk(paddr == e.pa, "R2/R3 physical address", paddr, e.pa);
          chk(cache_off == e.cd && write_thru == e.wt, "R7 caching hints",
              {30'b0, cache_off, write_thru}, {30'b0, e.cd, e.wt});
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic w, input logic u, input int l, input bit poke);
    lat = l;
    alog.delete();
    sb.push_back(model(va, w, u));
    @(negedge clk);
    while (busy) @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", {31'b0, busy}, 32'h1);
    if (poke) begin
      req_vaddr = 32'h0080_0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] LEAF = 32'h0002_0000;

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0001_0008] = 32'h0000_0000;
    mem[32'h0001_000C] = 32'hFF80_0087;
    mem[32'h0001_0010] = 32'h0002_0005;
    mem[LEAF + 12] = 32'hABCD_E00F;
    mem[LEAF + 16] = 32'h1234_5006;
    mem[LEAF + 20] = 32'h3333_3005;
    mem[LEAF + 24] = 32'h4444_4013;
    mem[LEAF + 28] = 32'h5555_5001;

    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !done && !fault && !mem_req, "R11 reset state", {28'b0, busy, done, fault, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R7 R6: user read of a 4 KB page
    walk(32'h0040_3123, 0, 1, 0, 0);
    chk(alog.size() == 4, "R6 accesses for 4 KB walk", alog.size(), 4);
    chk(alog[0] == 32'h0001_0004, "R1 first-level address", alog[0], 32'h0001_0004);
    chk(alog[2] == LEAF + 12, "R1 second-level address", alog[2], LEAF + 12);
    chk(mem[LEAF + 12][6:5] == 2'b01, "R6 leaf accessed only", {30'b0, mem[LEAF + 12][6:5]}, 32'h1);

    // R6: write sets dirty on the leaf, never on the directory
    walk(32'h0040_3123, 1, 1, 2, 1);
    chk(mem[LEAF + 12][6:5] == 2'b11, "R6 leaf dirty on write", {30'b0, mem[LEAF + 12][6:5]}, 32'h3);
    chk(mem[32'h0001_0004][6:5] == 2'b01, "R6 directory no dirty", {30'b0, mem[32'h0001_0004][6:5]}, 32'h1);
    // R10: poke during the walk was ignored
    chk(alog.size() == 4 && !mem_req, "R10 request while busy ignored", alog.size(), 4);

    // R4: leaf not present, no write-back of it
    walk(32'h0040_4000, 0, 1, 1, 0);
    chk(alog.size() == 3, "R4 no leaf write-back", alog.size(), 3);
    chk(mem[LEAF + 16] == 32'h1234_5006, "R4 leaf unchanged", mem[LEAF + 16], 32'h1234_5006);

    // R5
    walk(32'h0040_5ABC, 1, 1, 0, 0);
    walk(32'h0040_5ABC, 0, 1, 1, 0);
    walk(32'h0040_6010, 0, 1, 0, 0);
    walk(32'h0040_6010, 0, 0, 2, 0);
    walk(32'h0040_7000, 1, 1, 0, 0);

    // R4: directory not present
    walk(32'h0080_0000, 0, 0, 0, 0);
    chk(alog.size() == 1, "R4 directory fault single read", alog.size(), 1);

    // R3: large page, write
    walk(32'h00EA_BCDE, 1, 1, 1, 0);
    chk(alog.size() == 2, "R3 no second-level read", alog.size(), 2);
    chk(mem[32'h0001_000C][6:5] == 2'b01, "R6 large entry no dirty", {30'b0, mem[32'h0001_000C][6:5]}, 32'h1);

    // R5 at first level, then a pass through the same directory
    walk(32'h0100_3000, 1, 0, 0, 0);
    walk(32'h0100_3000, 0, 1, 0, 0);

    chk(sb.size() == 0, "R9 every request answered", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule